// File: doc/BRIEF.md
# Micro Channel Slave Cycle Decoder

This block is the bus-facing front end of an 8-bit Micro Channel slave with a 24-bit address space. All bus lines are assumed already level-shifted and synchronised to the local clock. While the address-latch strobe is low, the block captures the address, the memory/I-O line, the two status lines, the 24-bit qualifier and the per-slot setup line. From the two status lines it works out whether the cycle is a read or a write, and it drops the two reserved encodings. It then checks the latched address against one memory window and one I/O window. On a hit it drives card-select feedback low.

When the command strobe first goes low on a claimed cycle, the block sends a one-clock request to a local backend. The request carries the address, the direction, the space and the write data. The block can hold the channel-ready line not-ready for a programmable number of clocks, and the backend can cut that count short. Read data goes to a data register with its own output enable, which is released one clock after the command strobe rises. When the setup line is low the window decoder is bypassed and the cycle reads or writes a small register file of configuration bytes.

Top module: `mca_slave_decode`

## Requirements
- R1: After reset, sfdbk_n and chrdy are 1, and dout_oe and be_stb are 0.
- R2: The cycle direction is read when st0=1 and st1=0, and write when st0=0 and st1=1. mio=1 selects memory space and mio=0 selects I/O space. be_wr (1 = write) and be_io (1 = I/O) report these with each request.
- R3: A cycle whose st0 equals st1 is reserved. It is never claimed, raises no request, enables no read data and leaves chrdy at 1.
- R4: A cycle with setup_n=1 and a valid encoding drives sfdbk_n low from the clock after adl_n is sampled low until the clock after cmd_n is sampled high. This applies to a memory cycle whose address lies in the 16 KB window starting at 0x0C8000, and to an I/O cycle whose address bits 15:0 lie in the 8-port block starting at 0x0300. Addresses outside the window are not claimed.
- R5: A memory cycle latched with made24=0 is not claimed and raises no request, even inside the window.
- R6: I/O reads and writes inside the I/O window are claimed and passed to the backend with be_io=1.
- R7: On a claimed cycle, be_stb is high for exactly one clock, following the first clock edge that samples cmd_n low. be_addr then holds the latched address. On writes, be_wdata holds din as sampled at that edge.
- R8: On a claimed cycle, chrdy is 0 for exactly wait_cfg clocks, starting at the edge that raises be_stb. A wait_cfg of 0 never lowers chrdy.
- R9: If be_ready is sampled high while chrdy is 0, chrdy returns to 1 after that edge.
- R10: On a claimed read or a configuration read, dout_oe rises with the edge that first samples cmd_n low. It falls one clock after the edge that samples cmd_n high. dout carries be_rdata for window reads.
- R11: With setup_n latched low, a write stores din into configuration register addr[2:0] and a read returns it on dout. Such cycles never drive sfdbk_n, be_stb or wait states. The registers reset to 0.
- R12: Address and cycle type are taken only while adl_n is low. Changes to them after adl_n rises do not affect the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adl_n | input | 1 | Address-latch strobe, active low |
| cmd_n | input | 1 | Command strobe, active low |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| st0 | input | 1 | Status line 0 level |
| st1 | input | 1 | Status line 1 level |
| made24 | input | 1 | 1 = address fits in 24 bits |
| setup_n | input | 1 | Per-slot configuration setup, active low |
| addr | input | 24 | Bus address |
| din | input | 8 | Bus data into the slave |
| wait_cfg | input | 4 | Wait-state count 0 to 15 |
| be_ready | input | 1 | Backend done, ends wait states early |
| be_rdata | input | 8 | Backend read data |
| sfdbk_n | output | 1 | Card-select feedback, active low |
| chrdy | output | 1 | Channel ready, 0 = extend cycle |
| dout | output | 8 | Read data to bus |
| dout_oe | output | 1 | Read data output enable |
| be_stb | output | 1 | One-clock backend request |
| be_wr | output | 1 | Request is a write |
| be_io | output | 1 | Request is in I/O space |
| be_addr | output | 24 | Request address |
| be_wdata | output | 8 | Request write data |

## Verification
Feedback is due one clock after the latch strobe is sampled low. The request pulse, output enable, first not-ready clock and read data all appear with the edge that first samples the command strobe low. The output enable drops two edges after the strobe is driven high. Inputs change only on falling clock edges, and each result is read on the falling edge right after the rising edge that should produce it. Wait states are counted as the number of falling edges that see chrdy low, so each count must match wait_cfg, or the release point, exactly.

// File: rtl/mca_slave_decode.sv
module mca_slave_decode #(
  parameter logic [23:0] MEM_BASE = 24'h0C8000,
  parameter int          MEM_AW   = 14,
  parameter logic [15:0] IO_BASE  = 16'h0300,
  parameter int          IO_AW    = 3,
  parameter int          POS_N    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adl_n,
  input  logic        cmd_n,
  input  logic        mio,
  input  logic        st0,
  input  logic        st1,
  input  logic        made24,
  input  logic        setup_n,
  input  logic [23:0] addr,
  input  logic [7:0]  din,
  input  logic [3:0]  wait_cfg,
  input  logic        be_ready,
  input  logic [7:0]  be_rdata,
  output logic        sfdbk_n,
  output logic        chrdy,
  output logic [7:0]  dout,
  output logic        dout_oe,
  output logic        be_stb,
  output logic        be_wr,
  output logic        be_io,
  output logic [23:0] be_addr,
  output logic [7:0]  be_wdata
);
  localparam int PW = $clog2(POS_N);

  logic [23:0] lat_addr;
  logic        lat_mio, lat_st0, lat_st1, lat_m24, lat_setup_n;
  logic        cyc_live, cmd_q, cmd_q2;
  logic [3:0]  wcnt;
  logic [7:0]  pos_q [POS_N];

  wire typ_ok   = lat_st0 ^ lat_st1;
  wire is_rd    = lat_st0 & ~lat_st1;
  wire mem_hit  = lat_mio && lat_m24 && (lat_addr[23:MEM_AW] == MEM_BASE[23:MEM_AW]);
  wire io_hit   = !lat_mio && (lat_addr[15:IO_AW] == IO_BASE[15:IO_AW]);
  wire win      = cyc_live && typ_ok && lat_setup_n && (mem_hit || io_hit);
  wire pos_sel  = cyc_live && typ_ok && !lat_setup_n;
  wire cmd_fall = cmd_q & ~cmd_n;
  wire cmd_rise = ~cmd_q & cmd_n;
  wire [PW-1:0] pidx = lat_addr[PW-1:0];

  assign sfdbk_n = ~win;
  assign chrdy   = (wcnt == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0; lat_mio <= 1'b0; lat_st0 <= 1'b0; lat_st1 <= 1'b0;
      lat_m24 <= 1'b0; lat_setup_n <= 1'b1;
    end else if (!adl_n) begin
      lat_addr <= addr; lat_mio <= mio; lat_st0 <= st0; lat_st1 <= st1;
      lat_m24 <= made24; lat_setup_n <= setup_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b1; cmd_q2 <= 1'b1; cyc_live <= 1'b0;
    end else begin
      cmd_q  <= cmd_n;
      cmd_q2 <= cmd_q;
      if (!adl_n)        cyc_live <= 1'b1;
      else if (cmd_rise) cyc_live <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_stb <= 1'b0; be_wr <= 1'b0; be_io <= 1'b0; be_addr <= '0; be_wdata <= '0;
    end else begin
      be_stb <= cmd_fall && win;
      if (cmd_fall && win) begin
        be_wr   <= ~is_rd;
        be_io   <= ~lat_mio;
        be_addr <= lat_addr;
        if (!is_rd) be_wdata <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wcnt <= 4'd0;
    else if (cmd_fall && win)   wcnt <= wait_cfg;
    else if (wcnt != 4'd0)      wcnt <= be_ready ? 4'd0 : wcnt - 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; dout_oe <= 1'b0;
    end else begin
      if (!cmd_n && is_rd && (win || pos_sel))
        dout <= pos_sel ? pos_q[pidx] : be_rdata;
      if (cmd_fall && is_rd && (win || pos_sel)) dout_oe <= 1'b1;
      else if (cmd_q && !cmd_q2)                 dout_oe <= 1'b0;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < POS_N; gi++) begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q[gi] <= '0;
        else if (cmd_fall && pos_sel && !is_rd && pidx == PW'(gi)) pos_q[gi] <= din;
      end
    end
  endgenerate

  p_stb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    be_stb |=> !be_stb);
  p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    be_stb |-> (lat_st0 != lat_st1));
  p_made24_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfdbk_n && lat_mio) |-> lat_m24);
  p_oe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> $past(cmd_n));
  p_wait_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chrdy) |-> (!cmd_n && be_stb));
  p_pos_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_setup_n |-> (sfdbk_n && !be_stb));
endmodule

// File: tb/mca_slave_decode_test.sv
module mca_slave_decode_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adl_n = 1'b1, cmd_n = 1'b1, mio = 1'b0, st0 = 1'b1, st1 = 1'b1;
  logic made24 = 1'b1, setup_n = 1'b1, be_ready = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  din = '0, be_rdata = '0;
  logic [3:0]  wait_cfg = '0;
  logic sfdbk_n, chrdy, dout_oe, be_stb, be_wr, be_io;
  logic [7:0] dout, be_wdata;
  logic [23:0] be_addr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mca_slave_decode uut (
    .clk(clk), .rst_n(rst_n), .adl_n(adl_n), .cmd_n(cmd_n), .mio(mio),
    .st0(st0), .st1(st1), .made24(made24), .setup_n(setup_n), .addr(addr),
    .din(din), .wait_cfg(wait_cfg), .be_ready(be_ready), .be_rdata(be_rdata),
    .sfdbk_n(sfdbk_n), .chrdy(chrdy), .dout(dout), .dout_oe(dout_oe),
    .be_stb(be_stb), .be_wr(be_wr), .be_io(be_io), .be_addr(be_addr),
    .be_wdata(be_wdata));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input string req, input logic m, input logic s0, input logic s1,
                           input logic m24, input logic su, input logic [23:0] a,
                           input logic [7:0] wd, input logic [7:0] rdv,
                           input logic exp_claim, input logic exp_stb, input logic exp_oe,
                           input int exp_wait, input int rel_at,
                           input logic chk_dout, input logic [7:0] exp_dout,
                           input logic exp_wr, input logic exp_io);
    int stb_cnt = 0;
    int low = 0;
    @(negedge clk);
    mio = m; st0 = s0; st1 = s1; made24 = m24; setup_n = su; addr = a;
    din = wd; be_rdata = rdv; adl_n = 1'b0;
    @(negedge clk);
    chk(req, "sfdbk_n after latch", sfdbk_n, !exp_claim);
    adl_n = 1'b1; addr = 24'hFFFFFF; mio = ~m; made24 = 1'b0; st0 = 1'b0; st1 = 1'b0;
    @(negedge clk);
    cmd_n = 1'b0;
    @(negedge clk);
    if (be_stb) stb_cnt++;
    chk(req, "dout_oe at command", dout_oe, exp_oe);
    if (exp_stb) begin
      chk(req, "be_addr", be_addr, a);
      chk(req, "be_wr", be_wr, exp_wr);
      chk(req, "be_io", be_io, exp_io);
      if (exp_wr) chk(req, "be_wdata", be_wdata, wd);
    end
    if (chk_dout) chk(req, "dout", dout, exp_dout);
    while (!chrdy && low < 40) begin
      low++;
      if (low == rel_at) be_ready = 1'b1;
      @(negedge clk);
      if (be_stb) stb_cnt++;
    end
    be_ready = 1'b0;
    chk(req, "wait clocks", low, exp_wait);
    @(negedge clk);
    if (be_stb) stb_cnt++;
    cmd_n = 1'b1;
    @(negedge clk);
    if (be_stb) stb_cnt++;
    chk(req, "sfdbk_n released", sfdbk_n, 1'b1);
    chk(req, "dout_oe held past command", dout_oe, exp_oe);
    @(negedge clk);
    if (be_stb) stb_cnt++;
    chk(req, "dout_oe released", dout_oe, 1'b0);
    chk(req, "be_stb pulses", stb_cnt, exp_stb ? 1 : 0);
  endtask

  task automatic t_reset();
    chk("R1", "sfdbk_n", sfdbk_n, 1'b1);
    chk("R1", "chrdy", chrdy, 1'b1);
    chk("R1", "dout_oe", dout_oe, 1'b0);
    chk("R1", "be_stb", be_stb, 1'b0);
  endtask

  task automatic t_mem_read();
    wait_cfg = 4'd0;
    run_cycle("R2/R4/R10/R12 mem read", 1, 1, 0, 1, 1, 24'h0C8123, 8'h00, 8'hA5,
              1, 1, 1, 0, 0, 1, 8'hA5, 0, 0);
  endtask

  task automatic t_mem_write();
    wait_cfg = 4'd3;
    run_cycle("R2/R7/R8 mem write", 1, 0, 1, 1, 1, 24'h0CBFFF, 8'h3C, 8'h00,
              1, 1, 0, 3, 0, 0, 8'h00, 1, 0);
  endtask

  task automatic t_io();
    wait_cfg = 4'd2;
    run_cycle("R6 io read", 0, 1, 0, 1, 1, 24'h000305, 8'h00, 8'h77,
              1, 1, 1, 2, 0, 1, 8'h77, 0, 1);
    wait_cfg = 4'd0;
    run_cycle("R6 io write", 0, 0, 1, 1, 1, 24'h000300, 8'h81, 8'h00,
              1, 1, 0, 0, 0, 0, 8'h00, 1, 1);
    run_cycle("R4 io miss", 0, 1, 0, 1, 1, 24'h000308, 8'h00, 8'h11,
              0, 0, 0, 0, 0, 0, 8'h00, 0, 1);
  endtask

  task automatic t_made24();
    wait_cfg = 4'd4;
    run_cycle("R5 made24 low", 1, 1, 0, 0, 1, 24'h0C8010, 8'h00, 8'h22,
              0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic t_reserved();
    wait_cfg = 4'd5;
    run_cycle("R3 both low", 1, 0, 0, 1, 1, 24'h0C8010, 8'h00, 8'h33,
              0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
    run_cycle("R3 both high", 0, 1, 1, 1, 1, 24'h000301, 8'h00, 8'h33,
              0, 0, 0, 0, 0, 0, 8'h00, 0, 1);
  endtask

  task automatic t_mem_miss();
    wait_cfg = 4'd0;
    run_cycle("R4 above window", 1, 1, 0, 1, 1, 24'h0CC000, 8'h00, 8'h44,
              0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
    run_cycle("R4 below window", 1, 0, 1, 1, 1, 24'h0C7FFF, 8'h55, 8'h00,
              0, 0, 0, 0, 0, 0, 8'h00, 1, 0);
  endtask

  task automatic t_waits();
    wait_cfg = 4'd15;
    run_cycle("R8 full wait", 1, 1, 0, 1, 1, 24'h0C9000, 8'h00, 8'h66,
              1, 1, 1, 15, 0, 1, 8'h66, 0, 0);
    run_cycle("R9 early release", 1, 1, 0, 1, 1, 24'h0C9001, 8'h00, 8'h67,
              1, 1, 1, 2, 2, 1, 8'h67, 0, 0);
  endtask

  task automatic t_pos();
    wait_cfg = 4'd4;
    run_cycle("R11 pos write", 0, 0, 1, 1, 0, 24'h000005, 8'h9E, 8'h00,
              0, 0, 0, 0, 0, 0, 8'h00, 1, 1);
    run_cycle("R11 pos read back", 0, 1, 0, 1, 0, 24'h000005, 8'h00, 8'hEE,
              0, 0, 1, 0, 0, 1, 8'h9E, 0, 1);
    run_cycle("R11 pos other reg", 0, 1, 0, 1, 0, 24'h000002, 8'h00, 8'hEE,
              0, 0, 1, 0, 0, 1, 8'h00, 0, 1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_read();
    t_mem_write();
    t_io();
    t_made24();
    t_reserved();
    t_mem_miss();
    t_waits();
    t_pos();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule